// File: doc/BRIEF.md
# Fractional Audio Master Clock Divider

This block derives an audio master clock from one of four source clocks. The clock comes from a phase accumulator that advances in steps of a fraction value and wraps at a divide value. Software drives the block through two 32-bit registers on a single-cycle register bus. The control register holds an enable, a source select and a busy flag. The ratio register holds the fraction and divide fields. While the divider is off, the master clock output passes through the clock arriving on the pad input.

The ratio can be changed while the divider runs. The new ratio is handed to the source clock domain and applied only at an output clock edge. Further ratio writes are refused until the change has been acknowledged back in the bus domain. A disable request waits for the low phase of the output, so the clock never emits a shortened pulse, and the enable bit keeps reading 1 until the divider has really stopped.

Top module: `mclk_frac_div`

## Requirements
- R1: After reset both registers read 0x00000000, `mclk_oe_o` is 0 and `mclk_o` follows `mclk_pad_i`.
- R2: With ratio fraction F (ratio register bits 19:12) and divide D (bits 11:0), and F not above D, the time between an output rising edge and the rising edge F+1 edges later equals 2*(D+1) periods of the selected source.
- R3: While the divider runs, `mclk_oe_o` is 1 and `mclk_o` is the divided clock. Once it has stopped, `mclk_oe_o` is 0 and `mclk_o` follows `mclk_pad_i`.
- R4: Control bit 30 enables the divider. After it is written 0, it keeps reading 1 until the divider has stopped. The divider stops only while the output is low, so the last high phase has full length.
- R5: Control bits 25:24 select source clock 0..3. Writes to this field are ignored while control bit 30 reads 1.
- R6: A ratio register write while control bit 30 reads 0 updates the ratio at once and leaves control bit 31 at 0.
- R7: A ratio register write while control bit 30 reads 1 sets control bit 31 on the next cycle. While bit 31 is 1, ratio writes are ignored. Bit 31 clears once the divider has taken the new ratio, which happens at an output edge.
- R8: Control bits 29:26 and 23:0 and ratio bits 31:20 always read 0. The register offsets are 0x0 for control and 0x4 for ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_clk_i | input | 4 | Candidate source clocks |
| mclk_pad_i | input | 1 | Clock arriving on the pad when the divider is off |
| mclk_o | output | 1 | Master clock: divided clock or pad bypass |
| mclk_oe_o | output | 1 | Pad output enable, high while the divider runs |

## Verification
Errors in the accumulator or in the wrap comparison do not show within one period. They show as a mismatch in the time spanned by F+1 output periods, which the bench measures once per ratio pattern. A handshake toggle that is lost or doubled leaves control bit 31 stuck, or lets a second ratio write through. Either shows up within a few bus cycles of the write. A wrong stop condition shows at the control bit 30 readback, and as a shortened final high phase at `mclk_o` within one output half period.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int DIV_W    = 12;
  localparam int FRACT_W  = 8;
  localparam int N_SRC    = 4;
  localparam int SEL_W    = $clog2(N_SRC);
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int RATIO_W  = DIV_W + FRACT_W;
  localparam int ACC_W    = DIV_W + 1;
  localparam logic [ADDR_W-1:0] CTRL_OFF = 4'h0;
  localparam logic [ADDR_W-1:0] DIV_OFF  = 4'h4;
  localparam int BUSY_BIT = 31;
  localparam int OE_BIT   = 30;
  localparam int SEL_LSB  = 24;

  typedef struct packed {
    logic [FRACT_W-1:0] fract;
    logic [DIV_W-1:0]   div;
  } ratio_t;
endpackage

// File: rtl/mfd_sync.sv
module mfd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mfd_regs.sv
module mfd_regs
  import mfd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_s_i,
  input  logic              ack_s_i,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o,
  output ratio_t            ratio_o,
  output logic              req_o,
  output logic              busy_o,
  output logic              oe_rb_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] div_rd_o
);
  logic             en_q, req_q;
  logic [SEL_W-1:0] sel_q;
  ratio_t           ratio_q;
  logic             wr_ctrl, wr_div;

  assign wr_ctrl = wr_i && (addr_i == CTRL_OFF);
  assign wr_div  = wr_i && (addr_i == DIV_OFF);
  assign oe_rb_o = en_q | run_s_i;
  assign busy_o  = req_q ^ ack_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      ratio_q <= '0;
      req_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q <= wdata_i[OE_BIT];
        if (!oe_rb_o) sel_q <= wdata_i[SEL_LSB +: SEL_W];
      end
      if (wr_div && !busy_o) begin
        ratio_q <= ratio_t'(wdata_i[RATIO_W-1:0]);
        // running divider: hand the ratio over through the toggle handshake
        if (oe_rb_o) req_q <= ~req_q;
      end
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[BUSY_BIT] = busy_o;
    ctrl_rd_o[OE_BIT]   = oe_rb_o;
    ctrl_rd_o[SEL_LSB +: SEL_W] = sel_q;
    div_rd_o = '0;
    div_rd_o[RATIO_W-1:0] = ratio_q;
  end

  assign en_o    = en_q;
  assign sel_o   = sel_q;
  assign ratio_o = ratio_q;
  assign req_o   = req_q;
endmodule

// File: rtl/mfd_phase_gen.sv
module mfd_phase_gen
  import mfd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_s_i,
  input  logic   req_s_i,
  input  ratio_t ratio_i,
  output logic   clk_o,
  output logic   run_o,
  output logic   ack_o
);
  logic             run_q, out_q, ack_q;
  ratio_t           act_q;
  logic [ACC_W-1:0] acc_q, sum, modulus;
  logic             wrap, pend;

  assign sum     = acc_q + ACC_W'(act_q.fract) + ACC_W'(1);
  assign modulus = ACC_W'(act_q.div) + ACC_W'(1);
  assign wrap    = sum >= modulus;
  assign pend    = req_s_i ^ ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
      ack_q <= 1'b0;
      act_q <= '0;
      acc_q <= '0;
    end else if (!run_q) begin
      acc_q <= '0;
      out_q <= 1'b0;
      act_q <= ratio_i;
      ack_q <= req_s_i;
      if (en_s_i) run_q <= 1'b1;
    end else if (!en_s_i && !out_q) begin
      run_q <= 1'b0;  // stop only in the low phase
    end else if (wrap) begin
      out_q <= ~out_q;
      if (!en_s_i) run_q <= 1'b0;  // high phase just ended
      if (pend) begin
        act_q <= ratio_i;
        ack_q <= req_s_i;
        acc_q <= '0;
      end else begin
        acc_q <= sum - modulus;
      end
    end else begin
      acc_q <= sum;
    end
  end

  assign clk_o = out_q;
  assign run_o = run_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/mclk_frac_div.sv
module mclk_frac_div
  import mfd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_clk_i,
  input  logic              mclk_pad_i,
  output logic              mclk_o,
  output logic              mclk_oe_o
);
  logic             en_q, req_q, busy, oe_rb;
  logic             run_s, ack_s, en_s, req_s;
  logic             div_clk, div_out, div_run, div_ack;
  logic [SEL_W-1:0] sel_q;
  ratio_t           ratio_q;
  logic [DATA_W-1:0] ctrl_rd, div_rd;

  mfd_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .run_s_i  (run_s),
    .ack_s_i  (ack_s),
    .en_o     (en_q),
    .sel_o    (sel_q),
    .ratio_o  (ratio_q),
    .req_o    (req_q),
    .busy_o   (busy),
    .oe_rb_o  (oe_rb),
    .ctrl_rd_o(ctrl_rd),
    .div_rd_o (div_rd)
  );

  // select changes only while the divider is idle
  assign div_clk = src_clk_i[sel_q];

  mfd_sync #(.W(2)) u_to_div (
    .clk_i (div_clk), .rst_ni,
    .d_i   ({en_q, req_q}),
    .q_o   ({en_s, req_s})
  );

  mfd_phase_gen u_gen (
    .clk_i  (div_clk), .rst_ni,
    .en_s_i (en_s),
    .req_s_i(req_s),
    .ratio_i(ratio_q),
    .clk_o  (div_out),
    .run_o  (div_run),
    .ack_o  (div_ack)
  );

  mfd_sync #(.W(2)) u_to_bus (
    .clk_i, .rst_ni,
    .d_i   ({div_run, div_ack}),
    .q_o   ({run_s, ack_s})
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFF)     rdata_o = ctrl_rd;
    else if (addr_i == DIV_OFF) rdata_o = div_rd;
  end

  assign mclk_oe_o = div_run;
  assign mclk_o    = div_run ? div_out : mclk_pad_i;
endmodule

// File: rtl/mclk_frac_div_chk.sv
module mclk_frac_div_chk
  import mfd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] ctrl_rd_i,
  input logic [DATA_W-1:0] div_rd_i,
  input logic              busy_i,
  input logic              oe_rb_i
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd_i[29:26] == '0 && ctrl_rd_i[23:0] == '0 && div_rd_i[31:20] == '0); // R8

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && wr_i && addr_i == DIV_OFF |=> $stable(div_rd_i)); // R7

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_rb_i && !busy_i && wr_i && addr_i == DIV_OFF |=> busy_i); // R7

  AST_DIRECT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_rb_i && !busy_i && wr_i && addr_i == DIV_OFF |=> !busy_i); // R6

  AST_SEL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_rb_i && wr_i && addr_i == CTRL_OFF |=> $stable(ctrl_rd_i[25:24])); // R5
endmodule

bind mclk_frac_div mclk_frac_div_chk u_chk (
  .clk_i, .rst_ni, .wr_i, .addr_i,
  .ctrl_rd_i(ctrl_rd),
  .div_rd_i (div_rd),
  .busy_i   (busy),
  .oe_rb_i  (oe_rb)
);

// File: tb/sim_mclk_frac_div.sv
`timescale 1ns/1ps
module sim_mclk_frac_div;
  logic        clk_i = 0, rst_ni = 0, wr_i = 0, pad = 0;
  logic [3:0]  addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic        s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic        mclk_o, mclk_oe_o;
  int checks = 0, errors = 0;

  localparam int SRC_PS [4] = '{8000, 14000, 6000, 22000};
  // sel, fract, divide
  localparam int VEC [5][3] = '{'{0,0,0}, '{1,2,9}, '{2,4,6}, '{3,0,3}, '{0,6,6}};

  always #5  clk_i = ~clk_i;
  always #4  s0 = ~s0;
  always #7  s1 = ~s1;
  always #3  s2 = ~s2;
  always #11 s3 = ~s3;

  mclk_frac_div u0 (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .src_clk_i ({s3, s2, s1, s0}),
    .mclk_pad_i(pad), .mclk_o, .mclk_oe_o
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic wait_oe(input logic val);
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      rd(4'h0, d);
      if (d[30] == val) return;
    end
    chk("R4 enable readback settle", 0, 1);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      rd(4'h0, d);
      if (!d[31]) return;
    end
    chk("R7 busy clear", 1, 0);
  endtask

  task automatic measure(input string tag, input int f, input longint exp_ps);
    realtime t0;
    repeat (4) @(posedge mclk_o);
    t0 = $realtime;
    repeat (f + 1) @(posedge mclk_o);
    chk(tag, longint'(($realtime - t0) * 1000.0), exp_ps);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    realtime t_rise;
    // R1 reset state
    #23 rst_ni = 1;
    rd(4'h0, d); chk("R1 ctrl reset", d, 0);
    rd(4'h4, d); chk("R1 ratio reset", d, 0);
    chk("R1 oe reset", mclk_oe_o, 0);
    pad = 1; #1 chk("R1 bypass high", mclk_o, 1);
    pad = 0; #1 chk("R1 bypass low", mclk_o, 0);

    // R8 reserved bits
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R8 ratio reserved", d, 32'h000F_FFFF);
    wr(4'h0, 32'hBCFF_FFFF);
    rd(4'h0, d); chk("R8 ctrl reserved", d, 0);

    // R2 R3 R6 table of ratios
    foreach (VEC[i]) begin
      wr(4'h0, 0); wait_oe(0);
      wr(4'h4, (VEC[i][1] << 12) | VEC[i][2]);
      rd(4'h0, d); chk("R6 no flag on direct load", d[31], 0);
      rd(4'h4, d); chk("R6 direct ratio", d, (VEC[i][1] << 12) | VEC[i][2]);
      wr(4'h0, (32'h1 << 30) | (VEC[i][0] << 24));
      measure("R2 period", VEC[i][1], 2 * (VEC[i][2] + 1) * SRC_PS[VEC[i][0]]);
      chk("R3 oe while running", mclk_oe_o, 1);
    end

    // R5 select locked while enabled
    wr(4'h0, (32'h1 << 30) | (32'h1 << 24));
    rd(4'h0, d); chk("R5 sel locked", d[25:24], 0);

    // R7 update while running
    wr(4'h0, 0); wait_oe(0);
    wr(4'h4, 199);
    wr(4'h0, 32'h1 << 30);
    repeat (2) @(posedge mclk_o);
    wr(4'h4, (1 << 12) | 9);
    rd(4'h0, d); chk("R7 busy set", d[31], 1);
    wr(4'h4, (3 << 12) | 5);
    rd(4'h4, d); chk("R7 blocked write", d, (1 << 12) | 9);
    wait_idle();
    measure("R7 new ratio landed", 1, 2 * 10 * SRC_PS[0]);

    // R4 R5 shutdown waits for low phase
    wr(4'h0, 0); wait_oe(0);
    wr(4'h4, 49);
    wr(4'h0, (32'h1 << 30) | (32'h3 << 24));
    repeat (2) @(posedge mclk_o);
    t_rise = $realtime;
    wr(4'h0, 32'h2 << 24);
    repeat (5) @(negedge clk_i);
    rd(4'h0, d);
    chk("R4 enable reads 1 during shutdown", d[30], 1);
    chk("R5 sel locked during shutdown", d[25:24], 3);
    chk("R4 output still high", mclk_o, 1);
    wait_oe(0);
    chk("R4 full high phase", ($realtime - t_rise) >= 1100.0, 1);
    chk("R3 oe off after stop", mclk_oe_o, 0);
    pad = 1; #1 chk("R3 bypass after stop", mclk_o, 1);
    pad = 0;
    wr(4'h0, 32'h2 << 24);
    rd(4'h0, d); chk("R5 sel write while idle", d, 32'h0200_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule